// File: doc/BRIEF.md
# Serial NAND Operation Sequencer

This block sits between a flash controller's command logic and a byte-level serial frame engine. It takes one high-level operation at a time and expands it into an ordered list of frames. The operations are page read into the cache, page program, block erase and device reset. Each frame is described by an opcode, up to three address bytes, a data direction and a data length. Between steps the block reads the device status register and waits until the busy bit clears. It then decodes the failure and ECC bits that apply to the step that just ended, and reports a single result code.

Payload bytes never pass through this block. The frame engine moves them between the device and the data buffer, and the sequencer only supplies the byte count. That count is trimmed so that a transfer never runs past the end of the 2112-byte page cache, which holds 2048 main bytes and a 64-byte spare area starting at column 0x800. A programmable cycle limit bounds every status poll. A device that stays busy past the limit ends the operation with a timeout code. Reset uses two fixed idle intervals, given as cycle-count parameters: one before the reset frame and one after it.

Top module: `nand_op_seq`

## Requirements
- R1: After reset, `busy`, `done` and `fr_valid` are low.
- R2: A read (op_kind 0) issues 0x13 with three address bytes {0x00, row[15:8], row[7:0]}. It then polls status until ready, then issues 0x03 with three address bytes {cache byte0, column[7:0], 0xFF}, receive direction, and the trimmed length. On `fr_addr`, the first address byte is bits [23:16], the second is bits [15:8] and the third is bits [7:0].
- R3: Cache byte0 carries column[11:8] in bits [3:0] and row bit 6 in bit 4. The other bits of byte0 are zero.
- R4: On the final read poll, ECC field status[5:4]=01 gives result 1 and the cache read still runs. A field of 10 or 11 gives result 2 and ends the operation without the cache read. A field of 00 gives result 0.
- R5: A program (op_kind 1) issues 0x06 and then polls until ready. It then issues 0x02 with two address bytes {cache byte0, column[7:0]}, transmit direction and the trimmed length. Next comes 0x10 with the 3-byte row address, then a final poll. Status bit 3 on that poll gives result 3.
- R6: An erase (op_kind 2) issues 0x06, then 0xD8 with the 3-byte row address, then a final poll. Status bit 2 on that poll gives result 4.
- R7: Status bits are decoded only once bit 0 reads clear, and only on the operation's final poll. Each operation decodes only its own bits. Bits seen while busy, or on the ready-wait between steps, have no effect, and a clean final poll gives result 0.
- R8: A status poll frame is opcode 0x0F, with one address byte 0xC0, receive direction and length 1. It is reissued back to back while status bit 0 reads set.
- R9: A poll that returns status bit 0 set, when the cycles spent in that poll phase are at least `poll_limit`, ends the operation with result 5 and issues no further frames.
- R10: A reset (op_kind 3) first polls until ready. It then leaves `fr_valid` low for exactly HOLD_CYC cycles, issues 0xFF with no address, leaves `fr_valid` low for exactly SETTLE_CYC cycles, and polls until ready. The result is 0.
- R11: The data length of a cache frame is min(op_len, 2112 − column). It is 0 when the column is 2112 or more.
- R12: An op is accepted only while `busy` is low. A request while busy, including the `done` cycle, causes no frame and no extra `done`.
- R13: Frame fields hold steady while `fr_valid` is high until `fr_done`. `done` is a one-cycle pulse with `result` valid, and `busy` falls the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| op_valid | input | 1 | Operation request, sampled while idle |
| op_kind | input | 2 | 0 read, 1 program, 2 erase, 3 reset |
| op_row | input | 16 | Page or block row address |
| op_col | input | 12 | Cache column |
| op_len | input | 12 | Requested data byte count |
| poll_limit | input | 20 | Cycle limit per poll phase |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | 0 ok, 1 ECC corrected, 2 ECC uncorrectable, 3 program fail, 4 erase fail, 5 timeout |
| fr_valid | output | 1 | Frame request to the frame engine |
| fr_opcode | output | 8 | Frame opcode byte |
| fr_naddr | output | 2 | Number of address bytes, 0 to 3 |
| fr_addr | output | 24 | Address bytes, first byte in [23:16] |
| fr_rx | output | 1 | 1 when the data phase is received from the device |
| fr_len | output | 12 | Data phase byte count |
| fr_done | input | 1 | Frame engine finished the current frame |
| fr_stat | input | 8 | Received status byte, valid with `fr_done` on poll frames |

## Verification
Two coincidences are the most likely to break this block.

The first is a new request arriving in the same cycle as the `done` pulse. The bench raises `op_valid` in exactly that cycle. It then judges the outcome by counting frames and completion pulses over the following idle stretch.

The second is a status byte that carries the busy bit together with failure and ECC bits. Here the frame engine model returns such bytes while busy, and returns failure bits on the ready-wait between program steps. The scoreboard then expects the complete frame list and a clean or step-specific result.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_RESET = 2'd3
  } nseq_op_e;

  typedef enum logic [2:0] {
    RES_OK         = 3'd0,
    RES_ECC_FIX    = 3'd1,
    RES_ECC_BAD    = 3'd2,
    RES_PROG_FAIL  = 3'd3,
    RES_ERASE_FAIL = 3'd4,
    RES_TIMEOUT    = 3'd5
  } nseq_res_e;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_RD_LOAD,
    ST_RD_POLL,
    ST_RD_XFER,
    ST_PG_WEN,
    ST_PG_WPOLL,
    ST_PG_LOAD,
    ST_PG_EXEC,
    ST_PG_POLL,
    ST_ER_WEN,
    ST_ER_EXEC,
    ST_ER_POLL,
    ST_RS_POLL0,
    ST_RS_HOLD,
    ST_RS_CMD,
    ST_RS_SETTLE,
    ST_RS_POLL1,
    ST_DONE
  } nseq_st_e;

  typedef enum logic [1:0] {
    PK_READY,
    PK_READ,
    PK_PROG,
    PK_ERASE
  } nseq_pk_e;

  localparam logic [7:0] OPC_ARRAY_TO_CACHE = 8'h13;
  localparam logic [7:0] OPC_CACHE_OUT      = 8'h03;
  localparam logic [7:0] OPC_CACHE_IN       = 8'h02;
  localparam logic [7:0] OPC_COMMIT         = 8'h10;
  localparam logic [7:0] OPC_BLOCK_ERASE    = 8'hD8;
  localparam logic [7:0] OPC_WRITE_EN       = 8'h06;
  localparam logic [7:0] OPC_GET_FEATURE    = 8'h0F;
  localparam logic [7:0] OPC_SOFT_RESET     = 8'hFF;
  localparam logic [7:0] FEAT_STATUS        = 8'hC0;
  localparam logic [7:0] CACHE_PAD          = 8'hFF;

endpackage

// File: rtl/nand_seq_timer.sv
module nand_seq_timer #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [CNT_W-1:0] tick
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] tick_q, tick_d;

  always_comb begin
    if (clr)              tick_d = '0;
    else if (tick_q == TOP) tick_d = tick_q;
    else                  tick_d = tick_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= '0;
    else        tick_q <= tick_d;
  end

  assign tick = tick_q;

  // R9
  tick_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && tick_q != TOP) |=> tick_q == CNT_W'($past(tick_q) + 1'b1));

endmodule

// File: rtl/nand_stat_dec.sv
module nand_stat_dec
  import nand_seq_pkg::*;
(
  input  logic [7:0] stat,
  input  nseq_pk_e   kind,
  output nseq_res_e  res
);
  always_comb begin
    res = RES_OK;
    case (kind)
      PK_READ: begin
        case (stat[5:4])
          2'b01:   res = RES_ECC_FIX;
          2'b10,
          2'b11:   res = RES_ECC_BAD;
          default: res = RES_OK;
        endcase
      end
      PK_PROG:  if (stat[3]) res = RES_PROG_FAIL;
      PK_ERASE: if (stat[2]) res = RES_ERASE_FAIL;
      default:  res = RES_OK;
    endcase
  end
endmodule

// File: rtl/nand_frame_fmt.sv
module nand_frame_fmt
  import nand_seq_pkg::*;
#(
  parameter int ROW_W       = 16,
  parameter int COL_W       = 12,
  parameter int LEN_W       = 12,
  parameter int CACHE_BYTES = 2112,
  parameter int PLANE_BIT   = 6
) (
  input  nseq_st_e         st,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  input  logic [LEN_W-1:0] len,
  output logic             active,
  output logic             poll,
  output logic [7:0]       opcode,
  output logic [1:0]       naddr,
  output logic [23:0]      addr,
  output logic             rx,
  output logic [LEN_W-1:0] dlen
);
  localparam int CW = ((LEN_W > COL_W) ? LEN_W : COL_W) + 1;
  localparam logic [CW-1:0] CACHE_END = CW'(CACHE_BYTES);

  logic [CW-1:0]    room, len_x;
  logic [LEN_W-1:0] trim_len;
  logic [7:0]       cbyte0, cbyte1;
  logic [23:0]      row_addr;

  always_comb begin
    len_x    = CW'(len);
    room     = (CW'(col) >= CACHE_END) ? '0 : CACHE_END - CW'(col);
    trim_len = (len_x > room) ? LEN_W'(room) : len;
    cbyte0   = 8'(col >> 8);
    cbyte0[4] = cbyte0[4] | row[PLANE_BIT];
    cbyte1   = col[7:0];
    row_addr = 24'(row);
  end

  always_comb begin
    active = 1'b1;
    poll   = 1'b0;
    opcode = 8'h00;
    naddr  = 2'd0;
    addr   = 24'h0;
    rx     = 1'b0;
    dlen   = '0;
    case (st)
      ST_RD_LOAD: begin
        opcode = OPC_ARRAY_TO_CACHE; naddr = 2'd3; addr = row_addr;
      end
      ST_RD_XFER: begin
        opcode = OPC_CACHE_OUT; naddr = 2'd3; addr = {cbyte0, cbyte1, CACHE_PAD};
        rx = 1'b1; dlen = trim_len;
      end
      ST_PG_WEN, ST_ER_WEN: begin
        opcode = OPC_WRITE_EN;
      end
      ST_PG_LOAD: begin
        opcode = OPC_CACHE_IN; naddr = 2'd2; addr = {cbyte0, cbyte1, 8'h00};
        dlen = trim_len;
      end
      ST_PG_EXEC: begin
        opcode = OPC_COMMIT; naddr = 2'd3; addr = row_addr;
      end
      ST_ER_EXEC: begin
        opcode = OPC_BLOCK_ERASE; naddr = 2'd3; addr = row_addr;
      end
      ST_RS_CMD: begin
        opcode = OPC_SOFT_RESET;
      end
      ST_RD_POLL, ST_PG_WPOLL, ST_PG_POLL, ST_ER_POLL, ST_RS_POLL0, ST_RS_POLL1: begin
        poll = 1'b1; opcode = OPC_GET_FEATURE; naddr = 2'd1;
        addr = {FEAT_STATUS, 16'h0000}; rx = 1'b1; dlen = LEN_W'(1);
      end
      default: active = 1'b0;
    endcase
  end
endmodule

// File: rtl/nand_op_seq.sv
module nand_op_seq
  import nand_seq_pkg::*;
#(
  parameter int ROW_W       = 16,
  parameter int COL_W       = 12,
  parameter int LEN_W       = 12,
  parameter int CNT_W       = 20,
  parameter int CACHE_BYTES = 2112,
  parameter int HOLD_CYC    = 62500,
  parameter int SETTLE_CYC  = 250000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [1:0]       op_kind,
  input  logic [ROW_W-1:0] op_row,
  input  logic [COL_W-1:0] op_col,
  input  logic [LEN_W-1:0] op_len,
  input  logic [CNT_W-1:0] poll_limit,
  output logic             busy,
  output logic             done,
  output logic [2:0]       result,
  output logic             fr_valid,
  output logic [7:0]       fr_opcode,
  output logic [1:0]       fr_naddr,
  output logic [23:0]      fr_addr,
  output logic             fr_rx,
  output logic [LEN_W-1:0] fr_len,
  input  logic             fr_done,
  input  logic [7:0]       fr_stat
);
  localparam logic [CNT_W-1:0] HOLD_LAST   = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);

  nseq_st_e         st_q, st_d;
  nseq_res_e        res_q, res_d, dec_res;
  nseq_pk_e         kind;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic [LEN_W-1:0] len_q;
  logic             take, poll_frame, tick_clr;
  logic [CNT_W-1:0] tick;

  nand_frame_fmt #(
    .ROW_W(ROW_W), .COL_W(COL_W), .LEN_W(LEN_W), .CACHE_BYTES(CACHE_BYTES), .PLANE_BIT(6)
  ) u_fmt (
    .st(st_q), .row(row_q), .col(col_q), .len(len_q),
    .active(fr_valid), .poll(poll_frame), .opcode(fr_opcode), .naddr(fr_naddr),
    .addr(fr_addr), .rx(fr_rx), .dlen(fr_len)
  );

  always_comb begin
    case (st_q)
      ST_RD_POLL: kind = PK_READ;
      ST_PG_POLL: kind = PK_PROG;
      ST_ER_POLL: kind = PK_ERASE;
      default:    kind = PK_READY;
    endcase
  end

  nand_stat_dec u_dec (.stat(fr_stat), .kind(kind), .res(dec_res));

  assign tick_clr = (st_d != st_q);

  nand_seq_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tick_clr), .tick(tick)
  );

  // next-state process
  always_comb begin
    st_d  = st_q;
    res_d = res_q;
    take  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (op_valid) begin
          take  = 1'b1;
          res_d = RES_OK;
          case (op_kind)
            OP_READ:  st_d = ST_RD_LOAD;
            OP_PROG:  st_d = ST_PG_WEN;
            OP_ERASE: st_d = ST_ER_WEN;
            default:  st_d = ST_RS_POLL0;
          endcase
        end
      end
      ST_RS_HOLD:   if (tick == HOLD_LAST)   st_d = ST_RS_CMD;
      ST_RS_SETTLE: if (tick == SETTLE_LAST) st_d = ST_RS_POLL1;
      ST_DONE:      st_d = ST_IDLE;
      default: begin
        if (fr_done) begin
          if (poll_frame) begin
            if (fr_stat[0]) begin
              if (tick >= poll_limit) begin
                res_d = RES_TIMEOUT;
                st_d  = ST_DONE;
              end
            end else begin
              res_d = dec_res;
              case (st_q)
                ST_RD_POLL:  st_d = (dec_res == RES_ECC_BAD) ? ST_DONE : ST_RD_XFER;
                ST_PG_WPOLL: st_d = ST_PG_LOAD;
                ST_RS_POLL0: st_d = ST_RS_HOLD;
                default:     st_d = ST_DONE;
              endcase
            end
          end else begin
            case (st_q)
              ST_RD_LOAD: st_d = ST_RD_POLL;
              ST_PG_WEN:  st_d = ST_PG_WPOLL;
              ST_PG_LOAD: st_d = ST_PG_EXEC;
              ST_PG_EXEC: st_d = ST_PG_POLL;
              ST_ER_WEN:  st_d = ST_ER_EXEC;
              ST_ER_EXEC: st_d = ST_ER_POLL;
              ST_RS_CMD:  st_d = ST_RS_SETTLE;
              default:    st_d = ST_DONE;
            endcase
          end
        end
      end
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      res_q <= RES_OK;
      row_q <= '0;
      col_q <= '0;
      len_q <= '0;
    end else begin
      st_q  <= st_d;
      res_q <= res_d;
      if (take) begin
        row_q <= op_row;
        col_q <= op_col;
        len_q <= op_len;
      end
    end
  end

  assign busy   = (st_q != ST_IDLE);
  assign done   = (st_q == ST_DONE);
  assign result = res_q;

  // R12
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !busy) |=> busy);

  // R13
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_valid && !fr_done) |=> (fr_valid && $stable(fr_opcode) && $stable(fr_addr) && $stable(fr_len)));

  // R13
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !done));

  // R8
  repoll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_valid && fr_done && poll_frame && fr_stat[0] && (tick < poll_limit))
      |=> (fr_valid && fr_opcode == OPC_GET_FEATURE));

  // R9
  timeout_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_valid && fr_done && poll_frame && fr_stat[0] && (tick >= poll_limit))
      |=> (done && result == RES_TIMEOUT));

endmodule

// File: tb/nand_op_seq_test.sv
module nand_op_seq_test;
  localparam int HOLD   = 40;
  localparam int SETTLE = 60;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [1:0]  op_kind;
  logic [15:0] op_row;
  logic [11:0] op_col;
  logic [11:0] op_len;
  logic [19:0] poll_limit;
  logic        busy, done;
  logic [2:0]  result;
  logic        fr_valid, fr_rx;
  logic [7:0]  fr_opcode;
  logic [1:0]  fr_naddr;
  logic [23:0] fr_addr;
  logic [11:0] fr_len;
  logic        fr_done;
  logic [7:0]  fr_stat;

  always #2 clk = ~clk;

  nand_op_seq #(.HOLD_CYC(HOLD), .SETTLE_CYC(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .op_row(op_row), .op_col(op_col), .op_len(op_len), .poll_limit(poll_limit),
    .busy(busy), .done(done), .result(result),
    .fr_valid(fr_valid), .fr_opcode(fr_opcode), .fr_naddr(fr_naddr),
    .fr_addr(fr_addr), .fr_rx(fr_rx), .fr_len(fr_len),
    .fr_done(fr_done), .fr_stat(fr_stat)
  );

  int n_tests = 0;
  int n_fail  = 0;

  logic [54:0] fq[$];
  string       fq_req[$];
  logic [2:0]  rq[$];
  string       rq_req[$];

  int         busy_left  = 0;
  logic [7:0] busy_byte  = 8'h01;
  logic [7:0] final_byte = 8'h00;
  int         lat        = 0;
  int         wc         = 0;
  int         gapc       = 0;
  int         post_gap   = 0;
  int         frames_seen = 0;
  int         dones_seen  = 0;
  bit         finished    = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [54:0] mk(input logic [7:0] opc, input logic [1:0] na,
                                     input logic [23:0] ad, input logic rx,
                                     input logic [11:0] ln, input int gap);
    return {opc, na, ad, rx, ln, 8'(gap)};
  endfunction

  task automatic push_f(input logic [54:0] f, input string req);
    fq.push_back(f);
    fq_req.push_back(req);
  endtask

  task automatic push_r(input logic [2:0] r, input string req);
    rq.push_back(r);
    rq_req.push_back(req);
  endtask

  // frame engine model and frame monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      fr_done = 1'b0; fr_stat = 8'h00; wc = 0; gapc = 0;
    end else begin
      if (!busy) gapc = 0;
      else if (!fr_valid) gapc++;
      if (fr_done) begin
        fr_done = 1'b0;
      end else if (fr_valid) begin
        if (wc < lat) wc++;
        else begin
          wc = 0;
          frames_seen++;
          if (fr_opcode == 8'h0F) begin
            chk(fr_naddr == 2'd1 && fr_addr[23:16] == 8'hC0 && fr_rx && fr_len == 12'd1,
                "R8 status frame format", {fr_naddr, fr_addr, fr_rx, fr_len},
                {2'd1, 24'hC00000, 1'b1, 12'd1});
            if (gapc != 0) post_gap = gapc;
            if (busy_left > 0) begin fr_stat = busy_byte; busy_left--; end
            else fr_stat = final_byte;
          end else begin
            logic [54:0] a;
            a = {fr_opcode, fr_naddr, fr_addr, fr_rx, fr_len, 8'(gapc)};
            fr_stat = 8'h00;
            if (fq.size() == 0) chk(1'b0, "R12 unexpected frame", a, 0);
            else begin
              logic [54:0] e;
              string r;
              e = fq.pop_front();
              r = fq_req.pop_front();
              chk(a == e, r, a, e);
            end
          end
          gapc = 0;
          fr_done = 1'b1;
        end
      end
    end
  end

  // result monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      dones_seen++;
      if (rq.size() == 0) chk(1'b0, "R12 unexpected done", result, 0);
      else begin
        logic [2:0] e;
        string r;
        e = rq.pop_front();
        r = rq_req.pop_front();
        chk(result == e, r, result, e);
      end
      chk(fq.size() == 0, "R13 frames missing at done", fq.size(), 0);
    end
  end

  task automatic launch(input logic [1:0] k, input logic [15:0] row,
                        input logic [11:0] col, input logic [11:0] len);
    @(negedge clk);
    op_kind = k; op_row = row; op_col = col; op_len = len; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    chk(busy == 1'b1, "R12 busy after accept", busy, 1);
  endtask

  task automatic run_op(input logic [1:0] k, input logic [15:0] row,
                        input logic [11:0] col, input logic [11:0] len,
                        input int bl, input logic [7:0] fin);
    busy_left = bl; final_byte = fin;
    launch(k, row, col, len);
    @(posedge done);
    @(negedge clk);
    @(negedge clk);
    chk(busy == 1'b0, "R13 busy falls after done", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_kind = 2'd0; op_row = '0; op_col = '0; op_len = '0;
    poll_limit = 20'd1000; fr_done = 1'b0; fr_stat = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(done == 0, "R1 done", done, 0);
    chk(fr_valid == 0, "R1 fr_valid", fr_valid, 0);

    // R2 read, clean
    push_f(mk(8'h13, 2'd3, 24'h001234, 1'b0, 12'd0, 0), "R2 load frame");
    push_f(mk(8'h03, 2'd3, 24'h0010FF, 1'b1, 12'd16, 0), "R2 cache out frame");
    push_r(3'd0, "R2 result");
    run_op(2'd0, 16'h1234, 12'h010, 12'd16, 2, 8'h00);

    // R3 plane bit, R4 corrected, slower engine (R13)
    lat = 2;
    push_f(mk(8'h13, 2'd3, 24'h000047, 1'b0, 12'd0, 0), "R2 load frame");
    push_f(mk(8'h03, 2'd3, 24'h1800FF, 1'b1, 12'd64, 0), "R3 cache byte0 with row bit 6");
    push_r(3'd1, "R4 corrected");
    run_op(2'd0, 16'h0047, 12'h800, 12'd64, 1, 8'h10);
    lat = 0;

    // R4 uncorrectable, no cache read
    push_f(mk(8'h13, 2'd3, 24'h000100, 1'b0, 12'd0, 0), "R4 load frame");
    push_r(3'd2, "R4 uncorrectable 10");
    run_op(2'd0, 16'h0100, 12'h000, 12'd8, 0, 8'h20);
    push_f(mk(8'h13, 2'd3, 24'h000101, 1'b0, 12'd0, 0), "R4 load frame");
    push_r(3'd2, "R4 uncorrectable 11");
    run_op(2'd0, 16'h0101, 12'h000, 12'd8, 0, 8'h30);

    // R7 flags while busy ignored, R11 full page length
    busy_byte = 8'h3D;
    push_f(mk(8'h13, 2'd3, 24'h000002, 1'b0, 12'd0, 0), "R7 load frame");
    push_f(mk(8'h03, 2'd3, 24'h0000FF, 1'b1, 12'd2112, 0), "R11 full page length");
    push_r(3'd0, "R7 busy flags ignored");
    run_op(2'd0, 16'h0002, 12'h000, 12'd2112, 3, 8'h00);
    busy_byte = 8'h01;

    // R5 program
    push_f(mk(8'h06, 2'd0, 24'h0, 1'b0, 12'd0, 0), "R5 write enable");
    push_f(mk(8'h02, 2'd2, 24'h112300, 1'b0, 12'd32, 0), "R5 cache load");
    push_f(mk(8'h10, 2'd3, 24'h0000C5, 1'b0, 12'd0, 0), "R5 commit");
    push_r(3'd0, "R5 program ok");
    run_op(2'd1, 16'h00C5, 12'h123, 12'd32, 1, 8'h00);

    // R5 program fail; R7 same bit on the ready-wait is ignored
    push_f(mk(8'h06, 2'd0, 24'h0, 1'b0, 12'd0, 0), "R7 write enable");
    push_f(mk(8'h02, 2'd2, 24'h000000, 1'b0, 12'd4, 0), "R7 load after failing ready-wait");
    push_f(mk(8'h10, 2'd3, 24'h000003, 1'b0, 12'd0, 0), "R5 commit");
    push_r(3'd3, "R5 program fail");
    run_op(2'd1, 16'h0003, 12'h000, 12'd4, 0, 8'h08);

    // R7 program ignores ECC and erase bits
    push_f(mk(8'h06, 2'd0, 24'h0, 1'b0, 12'd0, 0), "R5 write enable");
    push_f(mk(8'h02, 2'd2, 24'h000000, 1'b0, 12'd4, 0), "R5 cache load");
    push_f(mk(8'h10, 2'd3, 24'h000004, 1'b0, 12'd0, 0), "R5 commit");
    push_r(3'd0, "R7 program ignores other bits");
    run_op(2'd1, 16'h0004, 12'h000, 12'd4, 0, 8'h34);

    // R11 trimming
    push_f(mk(8'h06, 2'd0, 24'h0, 1'b0, 12'd0, 0), "R5 write enable");
    push_f(mk(8'h02, 2'd2, 24'h083000, 1'b0, 12'd16, 0), "R11 trimmed to cache end");
    push_f(mk(8'h10, 2'd3, 24'h000005, 1'b0, 12'd0, 0), "R5 commit");
    push_r(3'd0, "R11 result");
    run_op(2'd1, 16'h0005, 12'h830, 12'd100, 0, 8'h00);
    push_f(mk(8'h06, 2'd0, 24'h0, 1'b0, 12'd0, 0), "R5 write enable");
    push_f(mk(8'h02, 2'd2, 24'h090000, 1'b0, 12'd0, 0), "R11 column past cache end");
    push_f(mk(8'h10, 2'd3, 24'h000006, 1'b0, 12'd0, 0), "R5 commit");
    push_r(3'd0, "R11 result");
    run_op(2'd1, 16'h0006, 12'h900, 12'd5, 0, 8'h00);

    // R6 erase
    push_f(mk(8'h06, 2'd0, 24'h0, 1'b0, 12'd0, 0), "R6 write enable");
    push_f(mk(8'hD8, 2'd3, 24'h000240, 1'b0, 12'd0, 0), "R6 erase frame");
    push_r(3'd0, "R6 erase ok");
    run_op(2'd2, 16'h0240, 12'h000, 12'd0, 2, 8'h00);
    push_f(mk(8'h06, 2'd0, 24'h0, 1'b0, 12'd0, 0), "R6 write enable");
    push_f(mk(8'hD8, 2'd3, 24'h000241, 1'b0, 12'd0, 0), "R6 erase frame");
    push_r(3'd4, "R6 erase fail");
    run_op(2'd2, 16'h0241, 12'h000, 12'd0, 0, 8'h04);
    push_f(mk(8'h06, 2'd0, 24'h0, 1'b0, 12'd0, 0), "R6 write enable");
    push_f(mk(8'hD8, 2'd3, 24'h000242, 1'b0, 12'd0, 0), "R6 erase frame");
    push_r(3'd0, "R7 erase ignores other bits");
    run_op(2'd2, 16'h0242, 12'h000, 12'd0, 0, 8'h38);

    // R10 reset with exact idle intervals
    post_gap = 0;
    push_f(mk(8'hFF, 2'd0, 24'h0, 1'b0, 12'd0, HOLD), "R10 reset frame after hold");
    push_r(3'd0, "R10 reset result");
    run_op(2'd3, 16'h0000, 12'h000, 12'd0, 1, 8'h00);
    chk(post_gap == SETTLE, "R10 settle interval", post_gap, SETTLE);

    // R9 timeout
    poll_limit = 20'd20;
    push_f(mk(8'h13, 2'd3, 24'h000009, 1'b0, 12'd0, 0), "R9 load frame");
    push_r(3'd5, "R9 timeout");
    run_op(2'd0, 16'h0009, 12'h000, 12'd8, 100000, 8'h00);
    busy_left = 0;
    poll_limit = 20'd1000;

    // R12 request in the done cycle is ignored
    begin
      int f0, d0;
      push_f(mk(8'h06, 2'd0, 24'h0, 1'b0, 12'd0, 0), "R6 write enable");
      push_f(mk(8'hD8, 2'd3, 24'h000300, 1'b0, 12'd0, 0), "R6 erase frame");
      push_r(3'd0, "R12 first op result");
      busy_left = 0; final_byte = 8'h00;
      launch(2'd2, 16'h0300, 12'h000, 12'd0);
      @(posedge done);
      @(negedge clk);
      op_kind = 2'd2; op_row = 16'h0777; op_valid = 1'b1;
      @(negedge clk);
      op_valid = 1'b0;
      f0 = frames_seen; d0 = dones_seen;
      repeat (30) @(negedge clk);
      chk(frames_seen == f0, "R12 no frames from request in done cycle", frames_seen, f0);
      chk(dones_seen == d0, "R12 no extra done", dones_seen, d0);
      chk(busy == 1'b0, "R12 stays idle", busy, 0);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule